// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Aggregator

This block gathers interrupt sources for a low-pin-count host bridge and reduces them to a single interrupt line through two latching stages. The front stage captures high levels on seventeen decoded serial interrupt lines, a bus-reset event and eight bus-cycle event bits into a sticky status word. It gates that word with a mask and a global enable to form one summary signal.

The back stage treats the summary signal as one bit of a 32-bit input word. On every clock it ORs the masked input into its own sticky status word, and it raises `irq_out` while that word is nonzero. Software reaches both stages through one 32-bit register port with byte offsets. Status bits are cleared by writing ones to them. A polarity word in the back stage is stored but has no effect on any logic.

Top module: `irq_cascade`

## Requirements
- R1: After a synchronous active-low reset, every readable register (0x30, 0x34, 0x38, 0x50, 0x54, 0x58) reads zero and `irq_out` is low.
- R2: A high level on `line_lvl[n]` at a clock edge sets front status bit (31-n) from that edge on, so line 0 maps to bit 31 and line 16 maps to bit 15. A low level never clears a bit.
- R3: A high `busrst_evt` sets front status bit 10, and a high `cyc_evt[k]` sets front status bit k for k = 0..7. Bits 14..11, 9 and 8 of the front status always read zero.
- R4: A write to 0x38 clears the front status bits where the write data holds ones, from the write's clock edge on. A source that is high in the same cycle keeps its bit set.
- R5: The summary signal is high only when bit 31 of the control word at 0x30 is set and (front status AND front mask at 0x34) is nonzero. It reads back combinationally as bit 11 (value 0x800) of the read-only input word at 0x5C.
- R6: On every clock edge the back status at 0x50 becomes (status AND NOT the cleared bits) OR (input word AND back mask at 0x54). A write to 0x50 clears the bits where its data holds ones, but a masked input that is still active re-sets its bit at that same edge. `irq_out` is high exactly while the back status is nonzero.
- R7: The polarity word at 0x58 reads back the last value written to it and changes neither the status words nor `irq_out`.
- R8: Writes to the input word at 0x5C are ignored.
- R9: The error-address word at 0x40 reads zero, and writes to it are ignored.
- R10: Reads of any offset not listed in R1, R5 or R9 return 0xFFFFFFFF, and writes to such offsets change nothing.
- R11: The control word (0x30), front mask (0x34) and back mask (0x54) read back all 32 bits last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| line_lvl | input | 17 | Decoded serial interrupt line levels |
| busrst_evt | input | 1 | Bus reset event |
| cyc_evt | input | 8 | Bus-cycle error and request events |
| irq_out | output | 1 | Final interrupt output |

## Verification
On every cycle the assertions check the following:
- A high level on line 0 is latched into the front status.
- Both status words stay sticky unless software writes their clear offset.
- The reserved front-status bits stay zero.
- An active summary with its back-mask bit set is latched into the back status.
- `irq_out` holds until the back status is cleared.

Only the bench scenarios can show the rest:
- the exact bit mapping of each source;
- the gating by the global enable;
- a clear losing to a source that is still active;
- the polarity word having no effect;
- all-ones reads from unmapped offsets, and ignored writes to them.

// File: rtl/irq_cascade_pkg.sv
// Shared constants for the cascaded interrupt aggregator: data width,
// byte offsets of every register, and fixed bit positions.
package irq_cascade_pkg;
    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] OFS_FCTRL = 8'h30;
    localparam logic [AW-1:0] OFS_FMASK = 8'h34;
    localparam logic [AW-1:0] OFS_FSTAT = 8'h38;
    localparam logic [AW-1:0] OFS_ERRA  = 8'h40;
    localparam logic [AW-1:0] OFS_BSTAT = 8'h50;
    localparam logic [AW-1:0] OFS_BMASK = 8'h54;
    localparam logic [AW-1:0] OFS_BPOL  = 8'h58;
    localparam logic [AW-1:0] OFS_BIN   = 8'h5C;

    localparam int EN_BIT     = 31;   // global enable in the control word
    localparam int BUSRST_BIT = 10;   // bus reset event in the front status
    localparam int SUM_BIT    = 11;   // summary position in the back input word
endpackage

// File: rtl/irq_front_stage.sv
// Front stage: latches line levels and event bits into a write-one-to-clear
// status word, holds control and mask words, and forms the summary signal.
// Assumes one register write per cycle at most; a set source beats a clear.
module irq_front_stage #(
    parameter int DW         = 32,
    parameter int NUM_LINES  = 17,
    parameter int NUM_CYC    = 8,
    parameter int EN_BIT     = 31,
    parameter int BUSRST_BIT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic                 wr_mask,
    input  logic                 wr_stat,
    input  logic [DW-1:0]        wdata,
    input  logic [NUM_LINES-1:0] line_lvl,
    input  logic                 busrst_evt,
    input  logic [NUM_CYC-1:0]   cyc_evt,
    output logic [DW-1:0]        ctrl_q,
    output logic [DW-1:0]        mask_q,
    output logic [DW-1:0]        stat_q,
    output logic                 summary
);
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;

    // Map each source to its status bit; lines are numbered from the top down.
    always_comb begin
        set_vec = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            set_vec[DW-1-n] = line_lvl[n];
        end
        set_vec[BUSRST_BIT] = busrst_evt;
        for (int k = 0; k < NUM_CYC; k++) begin
            set_vec[k] = cyc_evt[k];
        end
    end

    assign clr_vec = wr_stat ? wdata : '0;

    // Control and mask words: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_mask) mask_q <= wdata;
        end
    end

    // Sticky status: clear the written ones, then OR in active sources.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    assign summary = ctrl_q[EN_BIT] && ((stat_q & mask_q) != '0);
endmodule

// File: rtl/irq_back_stage.sv
// Back stage: the summary from the front stage forms one bit of the input
// word; the masked input is ORed into a sticky write-one-to-clear status each
// cycle. The polarity word is storage only. Assumes the summary is synchronous.
module irq_back_stage #(
    parameter int DW      = 32,
    parameter int SUM_BIT = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stat,
    input  logic          wr_mask,
    input  logic          wr_pol,
    input  logic [DW-1:0] wdata,
    input  logic          summary,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] pol_q,
    output logic [DW-1:0] in_vec,
    output logic          irq
);
    logic [DW-1:0] clr_vec;

    // Place the summary at its fixed input position; other inputs are idle.
    always_comb begin
        in_vec          = '0;
        in_vec[SUM_BIT] = summary;
    end

    assign clr_vec = wr_stat ? wdata : '0;

    // Mask and polarity words: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pol_q  <= '0;
        end else begin
            if (wr_mask) mask_q <= wdata;
            if (wr_pol)  pol_q  <= wdata;
        end
    end

    // Sticky status: clear the written ones, re-latch the masked input.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | (in_vec & mask_q);
    end

    assign irq = (stat_q != '0);
endmodule

// File: rtl/irq_reg_port.sv
// Register port: decodes write strobes by byte offset and muxes read data.
// Unmapped offsets read all ones; the error-address word reads zero.
// Assumes read data is sampled combinationally from the address.
module irq_reg_port
    import irq_cascade_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] f_ctrl,
    input  logic [DW-1:0] f_mask,
    input  logic [DW-1:0] f_stat,
    input  logic [DW-1:0] b_stat,
    input  logic [DW-1:0] b_mask,
    input  logic [DW-1:0] b_pol,
    input  logic [DW-1:0] b_in,
    output logic          wr_fctrl,
    output logic          wr_fmask,
    output logic          wr_fstat,
    output logic          wr_bstat,
    output logic          wr_bmask,
    output logic          wr_bpol,
    output logic [DW-1:0] rdata
);
    logic wr_any;
    assign wr_any = bus_sel && bus_wr;

    // Write strobes for the writable words only.
    always_comb begin
        wr_fctrl = wr_any && (bus_addr == OFS_FCTRL);
        wr_fmask = wr_any && (bus_addr == OFS_FMASK);
        wr_fstat = wr_any && (bus_addr == OFS_FSTAT);
        wr_bstat = wr_any && (bus_addr == OFS_BSTAT);
        wr_bmask = wr_any && (bus_addr == OFS_BMASK);
        wr_bpol  = wr_any && (bus_addr == OFS_BPOL);
    end

    // Read mux by offset.
    always_comb begin
        case (bus_addr)
            OFS_FCTRL: rdata = f_ctrl;
            OFS_FMASK: rdata = f_mask;
            OFS_FSTAT: rdata = f_stat;
            OFS_ERRA:  rdata = '0;
            OFS_BSTAT: rdata = b_stat;
            OFS_BMASK: rdata = b_mask;
            OFS_BPOL:  rdata = b_pol;
            OFS_BIN:   rdata = b_in;
            default:   rdata = '1;
        endcase
    end
endmodule

// File: rtl/irq_cascade.sv
// Top level: register port, front stage and back stage in cascade.
// All state resets synchronously to zero; status updates one edge after
// its cause, and the back stage follows the front stage by one more edge.
module irq_cascade
    import irq_cascade_pkg::*;
#(
    parameter int NUM_LINES = 17,
    parameter int NUM_CYC   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_LINES-1:0] line_lvl,
    input  logic                 busrst_evt,
    input  logic [NUM_CYC-1:0]   cyc_evt,
    output logic                 irq_out
);
    logic          wr_fctrl, wr_fmask, wr_fstat, wr_bstat, wr_bmask, wr_bpol;
    logic [DW-1:0] f_ctrl, f_mask, f_stat;
    logic [DW-1:0] b_stat, b_mask, b_pol, b_in;
    logic          summary;

    irq_reg_port #(.DW(DW), .AW(AW)) u_port (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .f_ctrl(f_ctrl), .f_mask(f_mask), .f_stat(f_stat),
        .b_stat(b_stat), .b_mask(b_mask), .b_pol(b_pol), .b_in(b_in),
        .wr_fctrl(wr_fctrl), .wr_fmask(wr_fmask), .wr_fstat(wr_fstat),
        .wr_bstat(wr_bstat), .wr_bmask(wr_bmask), .wr_bpol(wr_bpol),
        .rdata(bus_rdata)
    );

    irq_front_stage #(
        .DW(DW), .NUM_LINES(NUM_LINES), .NUM_CYC(NUM_CYC),
        .EN_BIT(EN_BIT), .BUSRST_BIT(BUSRST_BIT)
    ) u_front (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_fctrl), .wr_mask(wr_fmask), .wr_stat(wr_fstat),
        .wdata(bus_wdata), .line_lvl(line_lvl),
        .busrst_evt(busrst_evt), .cyc_evt(cyc_evt),
        .ctrl_q(f_ctrl), .mask_q(f_mask), .stat_q(f_stat),
        .summary(summary)
    );

    irq_back_stage #(.DW(DW), .SUM_BIT(SUM_BIT)) u_back (
        .clk(clk), .rst_n(rst_n),
        .wr_stat(wr_bstat), .wr_mask(wr_bmask), .wr_pol(wr_bpol),
        .wdata(bus_wdata), .summary(summary),
        .stat_q(b_stat), .mask_q(b_mask), .pol_q(b_pol), .in_vec(b_in),
        .irq(irq_out)
    );
endmodule

// File: rtl/irq_cascade_checker.sv
// Cycle-level properties of the aggregator, bound to the top module.
module irq_cascade_checker
    import irq_cascade_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic          line0,
    input logic [DW-1:0] f_stat,
    input logic          summary,
    input logic [DW-1:0] b_stat,
    input logic [DW-1:0] b_mask,
    input logic          irq_out
);
    localparam logic [DW-1:0] RSVD = 32'h0000_7B00;
    logic fclr, bclr;
    assign fclr = bus_sel && bus_wr && (bus_addr == OFS_FSTAT);
    assign bclr = bus_sel && bus_wr && (bus_addr == OFS_BSTAT);

    AST_LINE0_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        line0 |=> f_stat[DW-1]);                                      // R2
    AST_FRONT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !fclr |=> ((f_stat & $past(f_stat)) == $past(f_stat)));       // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (f_stat & RSVD) == '0);                                       // R3
    AST_SUM_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        summary |-> (f_stat != '0));                                  // R5
    AST_BACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (summary && b_mask[SUM_BIT]) |=> b_stat[SUM_BIT]);            // R6
    AST_BACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !bclr |=> ((b_stat & $past(b_stat)) == $past(b_stat)));       // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !bclr) |=> irq_out);                              // R6
endmodule

bind irq_cascade irq_cascade_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .line0(line_lvl[0]), .f_stat(f_stat),
    .summary(summary), .b_stat(b_stat), .b_mask(b_mask), .irq_out(irq_out)
);

// File: tb/sim_irq_cascade.sv
module sim_irq_cascade;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [16:0] line_lvl = '0;
    logic        busrst_evt = 1'b0;
    logic [7:0]  cyc_evt = '0;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_cascade u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_lvl(line_lvl), .busrst_evt(busrst_evt), .cyc_evt(cyc_evt),
        .irq_out(irq_out)
    );

    // {offset, write data, expected read-back}
    localparam logic [71:0] VEC [10] = '{
        {8'h30, 32'h8000_00A5, 32'h8000_00A5},  // R11
        {8'h34, 32'hFFFF_0000, 32'hFFFF_0000},  // R11
        {8'h54, 32'h1234_5678, 32'h1234_5678},  // R11
        {8'h58, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R7
        {8'h40, 32'h0000_BEEF, 32'h0000_0000},  // R9
        {8'h5C, 32'hFFFF_FFFF, 32'h0000_0000},  // R8
        {8'h10, 32'h0000_0001, 32'hFFFF_FFFF},  // R10
        {8'h3C, 32'h0000_0001, 32'hFFFF_FFFF},  // R10
        {8'h31, 32'h0000_0001, 32'hFFFF_FFFF},  // R10
        {8'hFC, 32'h0000_0001, 32'hFFFF_FFFF}   // R10
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // Table walk: write, then read back.
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check("R7/R8/R9/R10/R11 table", v, VEC[i][31:0]);
        end
        check("R10 unmapped write no irq", {31'b0, irq_out}, 32'h0);

        // R1: reset state
        @(negedge clk); rst_n = 1'b0;
        tick(2); rst_n = 1'b1; tick(1);
        rd(8'h30, v); check("R1 ctrl", v, 0);
        rd(8'h34, v); check("R1 fmask", v, 0);
        rd(8'h38, v); check("R1 fstat", v, 0);
        rd(8'h50, v); check("R1 bstat", v, 0);
        rd(8'h54, v); check("R1 bmask", v, 0);
        rd(8'h58, v); check("R1 bpol", v, 0);
        check("R1 irq", {31'b0, irq_out}, 0);

        // R2: line 0 and line 16 pulses; low levels clear nothing
        line_lvl[0] = 1'b1; tick(1); line_lvl[0] = 1'b0;
        rd(8'h38, v); check("R2 line0 -> bit31", v, 32'h8000_0000);
        line_lvl[16] = 1'b1; tick(1); line_lvl[16] = 1'b0;
        tick(3);
        rd(8'h38, v); check("R2 line16 -> bit15, sticky", v, 32'h8000_8000);

        // R3: bus reset and cycle events
        busrst_evt = 1'b1; cyc_evt = 8'hA5; tick(1);
        busrst_evt = 1'b0; cyc_evt = 8'h00;
        rd(8'h38, v); check("R3 event bits", v, 32'h8000_84A5);

        // R5: enable gates the summary
        wr(8'h34, 32'h0000_0400);
        wr(8'h54, 32'h0000_0800);
        rd(8'h5C, v); check("R5 summary off when disabled", v, 0);
        tick(2);
        check("R5 irq off when disabled", {31'b0, irq_out}, 0);
        wr(8'h30, 32'h8000_0000);
        rd(8'h5C, v); check("R5 summary at input bit 11", v, 32'h0000_0800);
        tick(1);
        check("R6 irq after back latch", {31'b0, irq_out}, 1);
        rd(8'h50, v); check("R6 back status", v, 32'h0000_0800);

        // R6: back status sticky after summary drops
        wr(8'h34, 32'h0);
        tick(2);
        check("R6 irq sticky", {31'b0, irq_out}, 1);
        rd(8'h5C, v); check("R5 summary drops with mask", v, 0);

        // R7: polarity has no effect
        wr(8'h58, 32'hFFFF_FFFF);
        tick(1);
        check("R7 irq unchanged by polarity", {31'b0, irq_out}, 1);
        wr(8'h50, 32'h0000_0800);
        check("R6 clear back status", {31'b0, irq_out}, 0);
        tick(2);
        check("R7 irq stays low with polarity set", {31'b0, irq_out}, 0);
        rd(8'h58, v); check("R7 polarity readback", v, 32'hFFFF_FFFF);

        // R4: write-one-to-clear front status, and set beats clear
        wr(8'h38, 32'h0000_0400);
        rd(8'h38, v); check("R4 clear bit10", v, 32'h8000_80A5);
        @(negedge clk);
        line_lvl[0] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h38; bus_wdata = 32'h8000_0000;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; line_lvl[0] = 1'b0;
        rd(8'h38, v); check("R4 active source wins", v, 32'h8000_80A5);
        wr(8'h38, 32'h8000_0000);
        rd(8'h38, v); check("R4 clear bit31", v, 32'h0000_80A5);

        // R8: input word is read-only
        wr(8'h5C, 32'hFFFF_FFFF);
        rd(8'h5C, v); check("R8 input ignores write", v, 0);
        check("R8 irq unaffected", {31'b0, irq_out}, 0);

        // R6: clear loses to a still-active masked input
        wr(8'h34, 32'h0000_0080);
        tick(1);
        check("R6 re-arm via bit7", {31'b0, irq_out}, 1);
        wr(8'h50, 32'h0000_0800);
        tick(1);
        check("R6 re-latch after clear", {31'b0, irq_out}, 1);
        rd(8'h50, v); check("R6 back status re-latched", v, 32'h0000_0800);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule